// File: doc/BRIEF.md
# Dual-Slot Token Handoff Between Clock Domains

This block carries transmit tokens from a system clock domain to a faster transmit clock domain that has no phase relation to it. A writer in the system domain collects requests for time codes, flow-control tokens and normal characters. It keeps each request pending until a buffer slot is free, then packs one token into that slot. A reader in the transmit domain pulls the token at the head slot when the downstream serializer asks for one. If the head slot is empty, the reader returns a result marked invalid, and the serializer can send filler in its place.

The buffer has two slots. Each slot has a change flag on the writer side and a change flag on the reader side. Each flag crosses to the other domain through a two-flop synchronizer. Each side keeps a one-bit pointer to its own head slot. The writer also applies permission inputs that follow the state of the link. It ranks the pending requests by priority, and it can place a flow-control token and a character in the same token.

Top module: `tkx_xfer`

## Requirements
- R1: The writer fills at most one slot per system cycle, and only a slot whose writer flag equals its synchronized reader flag. Filling a slot inverts that slot's writer flag and moves the write pointer to the other slot.
- R2: A read request finds a token when the synchronized writer flag of the head slot differs from the reader flag. The reader then copies the synchronized writer flag into its own flag and moves its pointer to the other slot.
- R3: `rd_valid` is a register that goes high for one transmit cycle after an edge on which `rd_req` was high and the head slot held a token. On an empty head slot, `rd_valid` stays low and the read pointer does not move.
- R4: The token fields on the read side are `rd_tc` (time code), `rd_fc` (flow control), `rd_pig` (flow control plus character), `rd_end` (end marker) and the 8-bit `rd_val`. A character with `ch_end`=1 arrives with `rd_end`=1 and `rd_val` equal to `ch_data`.
- R5: When characters are allowed, a pending time code goes out first. It goes out alone, with `rd_tc`=1 and `rd_val` equal to its value, and any pending character follows in a later token.
- R6: A pending character and a flow-control token that is due in the same cycle share one token, with `rd_fc`=1 and `rd_pig`=1.
- R7: Flow-control tokens are allowed, one cycle after the change, whenever `null_only` is low. `fct_ack` = `fct_req` & `tx_en` & allowed & no flow-control token pending.
- R8: Characters and time codes are allowed only while both `null_only` and `fct_only` are low, and only after the writer has packed at least one flow-control token since it was enabled.
- R9: A character is accepted only while characters are allowed and no character is pending. `ch_ack` = `ch_req` & `tx_en` & allowed & none pending. With the reader stalled, at most two tokens plus one pending character are held.
- R10: While `tx_en` is low, both sides clear their slot flags, their pointers, the pending requests and the permissions. No token from before the disable is delivered afterwards.
- R11: With unrelated clocks, every token that is packed is delivered exactly once and in the order it was packed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| tx_clk | input | 1 | Transmit clock, faster than sys_clk |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| tx_en | input | 1 | Transmit enable (system domain) |
| null_only | input | 1 | Link may send only filler |
| fct_only | input | 1 | Link may send filler and flow control only |
| fct_req | input | 1 | Flow-control token request |
| fct_ack | output | 1 | Flow-control request accepted |
| ch_req | input | 1 | Character request |
| ch_end | input | 1 | Character is an end marker |
| ch_data | input | 8 | Character value |
| ch_ack | output | 1 | Character request accepted |
| tc_req | input | 1 | Time code request pulse |
| tc_val | input | 8 | Time code value |
| rd_req | input | 1 | Reader asks for the head token (transmit domain) |
| rd_valid | output | 1 | Token returned this cycle |
| rd_tc | output | 1 | Token is a time code |
| rd_fc | output | 1 | Token carries flow control |
| rd_pig | output | 1 | Flow control plus character |
| rd_end | output | 1 | Character is an end marker |
| rd_val | output | 8 | Character or time value |

## Verification
The bench stalls the reader so that both slots fill and a third character waits in the pending register. It then checks that a fourth character is refused. A writer that ignored the free test would overwrite a held token, and the read stream would lose a character. In the same stalled state, the bench adds a flow-control request, and in a separate test a time code. A wrong priority or a missing merge would show as a reordered stream or an extra token. It also reads while the buffer is empty. A reader whose pointer moved on an empty slot would later look in the wrong slot and never return the next token. Last, it disables the block with tokens still held. A design that kept stale flags would replay those old tokens after it is enabled again.

// File: rtl/tkx_pkg.sv
package tkx_pkg;
    localparam int VAL_W = 8;
    localparam int SLOTS = 2;
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic             tc;
        logic             fc;
        logic             pig;
        logic             eop;
        logic [VAL_W-1:0] val;
    } tkx_tok_t;

    localparam int TOK_W = $bits(tkx_tok_t);

    function automatic tkx_tok_t tkx_empty_tok();
        tkx_tok_t t;
        t = '0;
        return t;
    endfunction
endpackage

// File: rtl/tkx_sync.sv
module tkx_sync #(
    parameter int W      = 1,
    parameter int STAGES = tkx_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tkx_writer.sv
module tkx_writer
    import tkx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tx_en,
    input  logic                  null_only,
    input  logic                  fct_only,
    input  logic                  fct_req,
    output logic                  fct_ack,
    input  logic                  ch_req,
    input  logic                  ch_end,
    input  logic [VAL_W-1:0]      ch_data,
    output logic                  ch_ack,
    input  logic                  tc_req,
    input  logic [VAL_W-1:0]      tc_val,
    input  logic [SLOTS-1:0]      rflag_s,
    output logic [SLOTS-1:0]      wflag,
    output logic [PTR_W-1:0]      wptr,
    output tkx_tok_t [SLOTS-1:0]  slots
);
    logic             allow_fc, allow_ch, sent_fc;
    logic             pend_fc, pend_ch, pend_tc, pend_end;
    logic [VAL_W-1:0] pend_val, pend_tval;

    logic     slot_free, have, wr, take_tc, take_fc, take_ch;
    tkx_tok_t nxt;

    always_comb begin
        slot_free = (wflag[wptr] == rflag_s[wptr]);
        nxt       = tkx_empty_tok();
        have      = 1'b0;
        take_tc   = 1'b0;
        take_fc   = 1'b0;
        take_ch   = 1'b0;
        if (allow_ch && pend_tc) begin
            nxt.tc  = 1'b1;
            nxt.val = pend_tval;
            have    = 1'b1;
            take_tc = 1'b1;
        end else begin
            if (allow_fc && (fct_req || pend_fc)) begin
                nxt.fc  = 1'b1;
                have    = 1'b1;
                take_fc = 1'b1;
            end
            if (allow_ch && pend_ch) begin
                nxt.pig = nxt.fc;
                nxt.eop = pend_end;
                nxt.val = pend_val;
                have    = 1'b1;
                take_ch = 1'b1;
            end
        end
        wr      = tx_en && have && slot_free;
        fct_ack = fct_req && tx_en && allow_fc && !pend_fc;
        ch_ack  = ch_req && tx_en && allow_ch && !pend_ch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else if (wr) begin
            slots[wptr] <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            wflag     <= '0;
            wptr      <= '0;
            allow_fc  <= 1'b0;
            allow_ch  <= 1'b0;
            sent_fc   <= 1'b0;
            pend_fc   <= 1'b0;
            pend_ch   <= 1'b0;
            pend_tc   <= 1'b0;
            pend_end  <= 1'b0;
            pend_val  <= '0;
            pend_tval <= '0;
        end else begin
            if (fct_req && allow_fc) pend_fc <= 1'b1;
            if (wr) begin
                wflag[wptr] <= ~wflag[wptr];
                wptr        <= wptr + 1'b1;
                if (take_tc) pend_tc <= 1'b0;
                if (take_ch) pend_ch <= 1'b0;
                if (take_fc) begin
                    pend_fc <= 1'b0;
                    sent_fc <= 1'b1;
                end
            end
            allow_fc <= !null_only;
            allow_ch <= !null_only && !fct_only && sent_fc;
            if (ch_req && allow_ch && !pend_ch) begin
                pend_ch  <= 1'b1;
                pend_end <= ch_end;
                pend_val <= ch_data;
            end
            if (tc_req) begin
                pend_tc   <= 1'b1;
                pend_tval <= tc_val;
            end
        end
    end
endmodule

// File: rtl/tkx_reader.sv
module tkx_reader
    import tkx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_s,
    input  logic [SLOTS-1:0]      wflag_s,
    input  tkx_tok_t [SLOTS-1:0]  slots,
    input  logic                  rd_req,
    output logic                  rd_valid,
    output tkx_tok_t              rd_tok,
    output logic [SLOTS-1:0]      rflag,
    output logic [PTR_W-1:0]      rptr
);
    logic [SLOTS-1:0] held;

    for (genvar s = 0; s < SLOTS; s++) begin : g_held
        assign held[s] = wflag_s[s] ^ rflag[s];
    end

    logic take;
    assign take = rd_req && held[rptr];

    always_ff @(posedge clk) begin
        if (rst || !en_s) begin
            rflag    <= '0;
            rptr     <= '0;
            rd_valid <= 1'b0;
            rd_tok   <= tkx_empty_tok();
        end else begin
            rd_valid <= take;
            if (take) begin
                rd_tok      <= slots[rptr];
                rflag[rptr] <= wflag_s[rptr];
                rptr        <= rptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tkx_xfer.sv
module tkx_xfer
    import tkx_pkg::*;
(
    input  logic             sys_clk,
    input  logic             tx_clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             null_only,
    input  logic             fct_only,
    input  logic             fct_req,
    output logic             fct_ack,
    input  logic             ch_req,
    input  logic             ch_end,
    input  logic [VAL_W-1:0] ch_data,
    output logic             ch_ack,
    input  logic             tc_req,
    input  logic [VAL_W-1:0] tc_val,
    input  logic             rd_req,
    output logic             rd_valid,
    output logic             rd_tc,
    output logic             rd_fc,
    output logic             rd_pig,
    output logic             rd_end,
    output logic [VAL_W-1:0] rd_val
);
    logic [SLOTS-1:0]     wflag, wflag_s, rflag, rflag_s;
    logic [PTR_W-1:0]     wptr, rptr;
    logic                 en_s;
    tkx_tok_t [SLOTS-1:0] slots;
    tkx_tok_t             rd_tok;

    tkx_writer u_wr (
        .clk(sys_clk), .rst(rst), .tx_en(tx_en),
        .null_only(null_only), .fct_only(fct_only),
        .fct_req(fct_req), .fct_ack(fct_ack),
        .ch_req(ch_req), .ch_end(ch_end), .ch_data(ch_data), .ch_ack(ch_ack),
        .tc_req(tc_req), .tc_val(tc_val),
        .rflag_s(rflag_s), .wflag(wflag), .wptr(wptr), .slots(slots)
    );

    tkx_sync #(.W(SLOTS)) u_sync_w2r (
        .clk(tx_clk), .rst(rst), .d(wflag), .q(wflag_s)
    );

    tkx_sync #(.W(1)) u_sync_en (
        .clk(tx_clk), .rst(rst), .d(tx_en), .q(en_s)
    );

    tkx_sync #(.W(SLOTS)) u_sync_r2w (
        .clk(sys_clk), .rst(rst), .d(rflag), .q(rflag_s)
    );

    tkx_reader u_rd (
        .clk(tx_clk), .rst(rst), .en_s(en_s), .wflag_s(wflag_s),
        .slots(slots), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_tok(rd_tok), .rflag(rflag), .rptr(rptr)
    );

    assign rd_tc  = rd_tok.tc;
    assign rd_fc  = rd_tok.fc;
    assign rd_pig = rd_tok.pig;
    assign rd_end = rd_tok.eop;
    assign rd_val = rd_tok.val;
endmodule

// File: rtl/tkx_xfer_chk.sv
module tkx_xfer_chk
    import tkx_pkg::*;
(
    input logic             sys_clk,
    input logic             tx_clk,
    input logic             rst,
    input logic             tx_en,
    input logic             en_s,
    input logic [SLOTS-1:0] wflag,
    input logic [SLOTS-1:0] rflag_s,
    input logic [PTR_W-1:0] wptr,
    input logic [SLOTS-1:0] rflag,
    input logic [PTR_W-1:0] rptr,
    input logic             rd_req,
    input logic             rd_valid,
    input logic             rd_tc,
    input logic             rd_fc,
    input logic             rd_pig,
    input logic             rd_end
);
    AST_ONE_FILL_PER_CYCLE: assert property (@(posedge sys_clk) disable iff (rst)
        $countones(wflag ^ $past(wflag)) <= 1); // R1
    AST_FILL_FREE_SLOT0: assert property (@(posedge sys_clk) disable iff (rst)
        (wflag[0] != $past(wflag[0])) && $past(tx_en) |-> $past(wflag[0] == rflag_s[0])); // R1
    AST_FILL_FREE_SLOT1: assert property (@(posedge sys_clk) disable iff (rst)
        (wflag[1] != $past(wflag[1])) && $past(tx_en) |-> $past(wflag[1] == rflag_s[1])); // R1
    AST_WPTR_WITH_FILL: assert property (@(posedge sys_clk) disable iff (rst)
        (wptr != $past(wptr)) && $past(tx_en) |-> $countones(wflag ^ $past(wflag)) == 1); // R1
    AST_READ_ONLY_ON_REQ: assert property (@(posedge tx_clk) disable iff (rst)
        rd_valid |-> $past(rd_req)); // R3
    AST_RPTR_ONLY_ON_READ: assert property (@(posedge tx_clk) disable iff (rst)
        (rptr != $past(rptr)) && $past(en_s) |-> rd_valid); // R2
    AST_TIME_CODE_ALONE: assert property (@(posedge tx_clk) disable iff (rst)
        rd_valid && rd_tc |-> !rd_fc && !rd_pig && !rd_end); // R5
    AST_PIGGY_HAS_FC: assert property (@(posedge tx_clk) disable iff (rst)
        rd_valid && rd_pig |-> rd_fc); // R6
    AST_WRITER_DISABLE_CLEAR: assert property (@(posedge sys_clk) disable iff (rst)
        !tx_en |=> (wflag == '0) && (wptr == '0)); // R10
    AST_READER_DISABLE_CLEAR: assert property (@(posedge tx_clk) disable iff (rst)
        !en_s |=> (rflag == '0) && (rptr == '0) && !rd_valid); // R10
endmodule

bind tkx_xfer tkx_xfer_chk u_chk (
    .sys_clk(sys_clk), .tx_clk(tx_clk), .rst(rst), .tx_en(tx_en), .en_s(en_s),
    .wflag(wflag), .rflag_s(rflag_s), .wptr(wptr), .rflag(rflag), .rptr(rptr),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_tc(rd_tc), .rd_fc(rd_fc),
    .rd_pig(rd_pig), .rd_end(rd_end)
);

// File: tb/tkx_xfer_tb.sv
`timescale 1ns/1ps
module tkx_xfer_tb;
    logic sys_clk = 1'b0, tx_clk = 1'b0, rst = 1'b1;
    logic tx_en = 1'b0, null_only = 1'b1, fct_only = 1'b1;
    logic fct_req = 1'b0, ch_req = 1'b0, ch_end = 1'b0, tc_req = 1'b0, rd_req = 1'b0;
    logic [7:0] ch_data = '0, tc_val = '0, rd_val;
    logic fct_ack, ch_ack, rd_valid, rd_tc, rd_fc, rd_pig, rd_end;

    int checks = 0, errors = 0;
    bit rd_run = 1'b0;
    logic [11:0] rxq[$];
    logic [11:0] expq[$];

    always #2.5  sys_clk = ~sys_clk;
    always #1.55 tx_clk  = ~tx_clk;

    tkx_xfer u_dut (
        .sys_clk(sys_clk), .tx_clk(tx_clk), .rst(rst), .tx_en(tx_en),
        .null_only(null_only), .fct_only(fct_only),
        .fct_req(fct_req), .fct_ack(fct_ack),
        .ch_req(ch_req), .ch_end(ch_end), .ch_data(ch_data), .ch_ack(ch_ack),
        .tc_req(tc_req), .tc_val(tc_val),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_tc(rd_tc), .rd_fc(rd_fc),
        .rd_pig(rd_pig), .rd_end(rd_end), .rd_val(rd_val)
    );

    function automatic logic [11:0] tk(bit tc, bit fc, bit pig, bit e, logic [7:0] v);
        return {tc, fc, pig, e, v};
    endfunction

    initial begin
        forever begin
            @(negedge tx_clk);
            if (rd_valid) rxq.push_back({rd_tc, rd_fc, rd_pig, rd_end, rd_val});
            rd_req = rd_run;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_sys(int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic do_char(logic [7:0] d, bit e, int tmo, output bit ok);
        ok = 1'b0;
        @(negedge sys_clk);
        ch_req = 1'b1; ch_data = d; ch_end = e;
        for (int i = 0; i < tmo && !ok; i++) begin
            #1;
            if (ch_ack) ok = 1'b1;
            else @(negedge sys_clk);
        end
        @(negedge sys_clk);
        ch_req = 1'b0;
    endtask

    task automatic do_fct(int tmo, output bit ok);
        ok = 1'b0;
        @(negedge sys_clk);
        fct_req = 1'b1;
        for (int i = 0; i < tmo && !ok; i++) begin
            #1;
            if (fct_ack) ok = 1'b1;
            else @(negedge sys_clk);
        end
        @(negedge sys_clk);
        fct_req = 1'b0;
    endtask

    task automatic send_char(string req, logic [7:0] d, bit e);
        bit ok;
        do_char(d, e, 60, ok);
        chk(req, "character accepted", 32'(ok), 32'd1);
        if (ok) expq.push_back(tk(0, 0, 0, e, d));
    endtask

    task automatic check_stream(string req);
        for (int i = 0; i < 400 && rxq.size() < expq.size(); i++) wait_sys(1);
        wait_sys(30);
        chk(req, "token count", 32'(rxq.size()), 32'(expq.size()));
        for (int i = 0; i < expq.size(); i++) begin
            if (i < rxq.size()) chk(req, $sformatf("token %0d", i), 32'(rxq[i]), 32'(expq[i]));
        end
        rxq.delete();
        expq.delete();
    endtask

    task automatic t_reset();
        bit ok;
        chk("R10", "rd_valid after reset", 32'(rd_valid), 32'd0);
        do_fct(3, ok);
        chk("R10", "fct refused while disabled", 32'(ok), 32'd0);
        do_char(8'h11, 0, 3, ok);
        chk("R10", "char refused while disabled", 32'(ok), 32'd0);
    endtask

    task automatic t_startup();
        bit ok;
        tx_en = 1'b1; null_only = 1'b1; fct_only = 1'b0; rd_run = 1'b1;
        wait_sys(6);
        do_fct(4, ok);
        chk("R7", "fct refused in null-only state", 32'(ok), 32'd0);
        do_char(8'h22, 0, 4, ok);
        chk("R8", "char refused in null-only state", 32'(ok), 32'd0);
        null_only = 1'b0;
        wait_sys(3);
        do_char(8'h23, 0, 6, ok);
        chk("R8", "char refused before first fct", 32'(ok), 32'd0);
        do_fct(4, ok);
        chk("R7", "fct accepted when allowed", 32'(ok), 32'd1);
        expq.push_back(tk(0, 1, 0, 0, 8'h00));
        check_stream("R7");
        fct_only = 1'b1;
        wait_sys(3);
        do_char(8'h24, 0, 6, ok);
        chk("R8", "char refused in fct-only state", 32'(ok), 32'd0);
        fct_only = 1'b0;
        wait_sys(3);
    endtask

    task automatic t_stream();
        rd_run = 1'b1;
        for (int i = 0; i < 6; i++) send_char("R11", 8'h40 + 8'(i * 7), 0);
        check_stream("R11");
        wait_sys(20);
        chk("R3", "no token on empty reads", 32'(rxq.size()), 32'd0);
        send_char("R3", 8'h5A, 0);
        check_stream("R2");
    endtask

    task automatic t_end_marker();
        rd_run = 1'b1;
        send_char("R4", 8'h01, 1);
        send_char("R4", 8'h00, 1);
        send_char("R4", 8'hC3, 0);
        check_stream("R4");
    endtask

    task automatic fill_stalled(logic [7:0] base);
        rd_run = 1'b0;
        wait_sys(10);
        send_char("R9", base, 0);
        send_char("R9", base + 8'd1, 0);
        send_char("R9", base + 8'd2, 0);
    endtask

    task automatic t_backpressure();
        bit ok;
        fill_stalled(8'h60);
        do_char(8'h63, 0, 30, ok);
        chk("R9", "fourth char refused while full", 32'(ok), 32'd0);
        rd_run = 1'b1;
        send_char("R9", 8'h63, 0);
        check_stream("R1");
    endtask

    task automatic t_piggy();
        bit ok;
        fill_stalled(8'h70);
        do_fct(4, ok);
        chk("R6", "fct accepted while stalled", 32'(ok), 32'd1);
        void'(expq.pop_back());
        expq.push_back(tk(0, 1, 1, 0, 8'h72));
        rd_run = 1'b1;
        check_stream("R6");
    endtask

    task automatic t_tc_priority();
        logic [11:0] last;
        fill_stalled(8'h80);
        @(negedge sys_clk);
        tc_req = 1'b1; tc_val = 8'hA5;
        @(negedge sys_clk);
        tc_req = 1'b0;
        last = expq.pop_back();
        expq.push_back(tk(1, 0, 0, 0, 8'hA5));
        expq.push_back(last);
        rd_run = 1'b1;
        check_stream("R5");
    endtask

    task automatic t_disable();
        bit ok;
        fill_stalled(8'h90);
        expq.delete();
        tx_en = 1'b0;
        wait_sys(20);
        do_char(8'h99, 0, 4, ok);
        chk("R10", "char refused while disabled", 32'(ok), 32'd0);
        rd_run = 1'b1;
        wait_sys(20);
        chk("R10", "no stale token while disabled", 32'(rxq.size()), 32'd0);
        tx_en = 1'b1;
        wait_sys(4);
        do_char(8'h9A, 0, 6, ok);
        chk("R8", "char refused until fct after re-enable", 32'(ok), 32'd0);
        do_fct(4, ok);
        chk("R10", "fct accepted after re-enable", 32'(ok), 32'd1);
        expq.push_back(tk(0, 1, 0, 0, 8'h00));
        wait_sys(6);
        send_char("R10", 8'h9B, 0);
        check_stream("R10");
    endtask

    initial begin
        repeat (150000) @(posedge sys_clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_sys(10);
        rst = 1'b0;
        wait_sys(2);
        t_reset();
        t_startup();
        t_stream();
        t_end_marker();
        t_backpressure();
        t_piggy();
        t_tc_priority();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule